// File: doc/BRIEF.md
# Fractional Configuration Clock Divider

This block derives the configuration clock that paces a configuration data serializer. One of two source clocks is picked, either an internal oscillator or an external clock pin. That source is then divided by any whole number from 1 to 16, or by 1.5 or 2.5. The block uses both edges of the source. This gives whole-number ratios an exact 50% duty cycle, and it lets the two fractional ratios run at three or five source half-periods per output period.

Next to the divided clock, the block drives an enable strobe in the source-clock domain. The strobe lasts one source cycle and marks the cycle in which each output period begins. The serializer drives a pause input when it runs out of data. While pause is held, the output stays low and the phase position is frozen, so the clock resumes exactly where it stopped.

A new divide setting is only taken up when the phase counter wraps. Because of this, a change never truncates a period or produces a runt pulse. After reset the block starts from divide-by-1 on the internal source.

Top module: `cfg_clk_div`

## Requirements
- R1: While reset is low, clk_out and clk_en are low. After release, the first source cycle without pause starts a new output period with the setting present on div_sel.
- R2: src_sel = 0 selects osc_clk and src_sel = 1 selects ext_clk as the source. src_sel is only changed while reset is low.
- R3: A div_sel code c from 0 to 15 divides by N = c + 1. Each output period spans 2N source half-periods and is high for the first N of them, which gives 50% duty.
- R4: div_sel code 16 divides by 1.5. Each output period spans 3 source half-periods and is high for the first 2.
- R5: div_sel code 17 divides by 2.5. Each output period spans 5 source half-periods and is high for the first 3.
- R6: div_sel codes 18 to 31 divide by 1.
- R7: clk_en is high for exactly those source cycles (rising edge to rising edge) in which an output period begins.
- R8: A div_sel change is applied only when the phase counter wraps. For whole-number ratios that is the end of an output period. For 1.5 and 2.5 it is the end of every second output period.
- R9: pause is sampled on each rising source edge. When it is high, that source cycle keeps clk_out low in both halves and clk_en low, and the phase does not advance. Output resumes from the frozen phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Internal oscillator clock |
| ext_clk | input | 1 | External clock pin |
| src_sel | input | 1 | Source select: 0 oscillator, 1 external |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 5 | Divide setting code |
| pause | input | 1 | Serializer request to hold the clock |
| clk_out | output | 1 | Divided configuration clock |
| clk_en | output | 1 | One-source-cycle strobe at each output period start |

## Verification
On every rising source edge, the assertions check the pause behaviour: a paused cycle freezes the phase and suppresses both the strobe and the rising-half output. They also check that the active ratio only changes right after a phase wrap, and that every wrap is followed by a strobe. The exact high and low pattern of each half-period is compared against a half-period reference model in the bench, for every ratio, for mid-period setting changes, for pauses and for both sources. This includes the odd-ratio duty and the placement of the fractional periods, which only the bench scenarios can show.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;

   typedef enum logic [1:0] {
      RK_WHOLE      = 2'd0,
      RK_THREE_HALF = 2'd1,
      RK_FIVE_HALF  = 2'd2
   } ratio_kind_e;

   // Output period length counted in source half-periods.
   function automatic int half_len(ratio_kind_e k, int n);
      case (k)
         RK_THREE_HALF: return 3;
         RK_FIVE_HALF:  return 5;
         default:       return 2 * n;
      endcase
   endfunction

   // Source cycles before the phase counter wraps.
   function automatic int cyc_len(ratio_kind_e k, int n);
      if (k == RK_WHOLE) return n;
      return half_len(k, n);
   endfunction

   // Output level in half-period t of the wrap window.
   function automatic logic high_at(ratio_kind_e k, int n, int t);
      int h;
      int hi;
      h  = half_len(k, n);
      hi = (k == RK_WHOLE) ? n : (h + 1) / 2;
      return ((t % h) < hi);
   endfunction

   // True when an output period starts inside source cycle c.
   function automatic logic starts_in(ratio_kind_e k, int n, int c);
      if (c == 0) return 1'b1;
      if (k != RK_WHOLE && c == (half_len(k, n) - 1) / 2) return 1'b1;
      return 1'b0;
   endfunction

endpackage

// File: rtl/cdiv_src_sel.sv
`timescale 1ns/1ps
module cdiv_src_sel (
   input  logic osc_clk,
   input  logic ext_clk,
   input  logic src_sel,
   output logic src_clk
);
   // Static selection: src_sel only moves while the block is in reset.
   always_comb begin
      src_clk = src_sel ? ext_clk : osc_clk;
   end
endmodule

// File: rtl/cdiv_decode.sv
`timescale 1ns/1ps
module cdiv_decode
   import cdiv_pkg::*;
#(
   parameter int MAX_INT_DIV = 16,
   parameter int SEL_W       = 5,
   parameter int NW          = 5,
   parameter bit ENABLE_FRAC = 1'b1
) (
   input  logic [SEL_W-1:0] code,
   output ratio_kind_e      kind,
   output logic [NW-1:0]    n
);
   generate
      if (ENABLE_FRAC) begin : g_frac
         always_comb begin
            kind = RK_WHOLE;
            n    = NW'(1);
            if (int'(code) < MAX_INT_DIV) begin
               n = NW'(int'(code) + 1);
            end else if (int'(code) == MAX_INT_DIV) begin
               kind = RK_THREE_HALF;
            end else if (int'(code) == MAX_INT_DIV + 1) begin
               kind = RK_FIVE_HALF;
            end
         end
      end else begin : g_whole
         always_comb begin
            kind = RK_WHOLE;
            n    = NW'(1);
            if (int'(code) < MAX_INT_DIV) begin
               n = NW'(int'(code) + 1);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cdiv_phase.sv
`timescale 1ns/1ps
module cdiv_phase
   import cdiv_pkg::*;
#(
   parameter int CNT_W = 4,
   parameter int NW    = 5,
   parameter int DEF_N = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ratio_kind_e      dec_kind,
   input  logic [NW-1:0]    dec_n,
   input  logic             pause,
   output ratio_kind_e      act_kind,
   output logic [NW-1:0]    act_n,
   output logic [CNT_W-1:0] phase,
   output logic             wrap,
   output logic             run,
   output logic             q_rise,
   output logic             strobe
);
   logic             at_last;
   ratio_kind_e      nxt_kind;
   logic [NW-1:0]    nxt_n;
   logic [CNT_W-1:0] nxt_phase;

   always_comb begin
      at_last   = (int'(phase) == cyc_len(act_kind, int'(act_n)) - 1);
      nxt_kind  = at_last ? dec_kind : act_kind;
      nxt_n     = at_last ? dec_n : act_n;
      nxt_phase = at_last ? CNT_W'(0) : phase + CNT_W'(1);
      wrap      = at_last && !pause;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_kind <= RK_WHOLE;
         act_n    <= NW'(DEF_N);
         phase    <= CNT_W'(DEF_N - 1);
         run      <= 1'b0;
         q_rise   <= 1'b0;
         strobe   <= 1'b0;
      end else if (!pause) begin
         act_kind <= nxt_kind;
         act_n    <= nxt_n;
         phase    <= nxt_phase;
         run      <= 1'b1;
         q_rise   <= high_at(nxt_kind, int'(nxt_n), 2 * int'(nxt_phase));
         strobe   <= starts_in(nxt_kind, int'(nxt_n), int'(nxt_phase));
      end else begin
         run      <= 1'b0;
         q_rise   <= 1'b0;
         strobe   <= 1'b0;
      end
   end
endmodule

// File: rtl/cdiv_fall_half.sv
`timescale 1ns/1ps
module cdiv_fall_half
   import cdiv_pkg::*;
#(
   parameter int CNT_W = 4,
   parameter int NW    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ratio_kind_e      kind,
   input  logic [NW-1:0]    n,
   input  logic [CNT_W-1:0] phase,
   input  logic             run,
   output logic             q_fall
);
   // Level for the low half of the current source cycle (odd half index).
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_fall <= 1'b0;
      end else begin
         q_fall <= run ? high_at(kind, int'(n), 2 * int'(phase) + 1) : 1'b0;
      end
   end
endmodule

// File: rtl/cfg_clk_div.sv
`timescale 1ns/1ps
module cfg_clk_div
   import cdiv_pkg::*;
#(
   parameter int MAX_INT_DIV = 16,
   parameter int SEL_W       = 5,
   parameter int DEF_N       = 1,
   parameter bit ENABLE_FRAC = 1'b1
) (
   input  logic             osc_clk,
   input  logic             ext_clk,
   input  logic             src_sel,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] div_sel,
   input  logic             pause,
   output logic             clk_out,
   output logic             clk_en
);
   localparam int NW      = $clog2(MAX_INT_DIV + 1);
   localparam int MAX_CYC = (MAX_INT_DIV > 5) ? MAX_INT_DIV : 5;
   localparam int CNT_W   = $clog2(MAX_CYC);

   generate
      if (MAX_INT_DIV < 2) begin : g_bad_max
         $error("MAX_INT_DIV must be at least 2");
      end
      if (SEL_W < $clog2(MAX_INT_DIV + 2)) begin : g_bad_sel
         $error("SEL_W too narrow for the fractional codes");
      end
      if (DEF_N < 1 || DEF_N > MAX_INT_DIV) begin : g_bad_def
         $error("DEF_N out of range");
      end
   endgenerate

   logic             src_clk;
   ratio_kind_e      dec_kind;
   logic [NW-1:0]    dec_n;
   ratio_kind_e      act_kind;
   logic [NW-1:0]    act_n;
   logic [CNT_W-1:0] phase;
   logic             wrap;
   logic             run;
   logic             q_rise;
   logic             q_fall;

   cdiv_src_sel u_src (
      .osc_clk (osc_clk),
      .ext_clk (ext_clk),
      .src_sel (src_sel),
      .src_clk (src_clk)
   );

   cdiv_decode #(
      .MAX_INT_DIV (MAX_INT_DIV),
      .SEL_W       (SEL_W),
      .NW          (NW),
      .ENABLE_FRAC (ENABLE_FRAC)
   ) u_dec (
      .code (div_sel),
      .kind (dec_kind),
      .n    (dec_n)
   );

   cdiv_phase #(
      .CNT_W (CNT_W),
      .NW    (NW),
      .DEF_N (DEF_N)
   ) u_phase (
      .clk      (src_clk),
      .rst_n    (rst_n),
      .dec_kind (dec_kind),
      .dec_n    (dec_n),
      .pause    (pause),
      .act_kind (act_kind),
      .act_n    (act_n),
      .phase    (phase),
      .wrap     (wrap),
      .run      (run),
      .q_rise   (q_rise),
      .strobe   (clk_en)
   );

   cdiv_fall_half #(
      .CNT_W (CNT_W),
      .NW    (NW)
   ) u_fall (
      .clk    (src_clk),
      .rst_n  (rst_n),
      .kind   (act_kind),
      .n      (act_n),
      .phase  (phase),
      .run    (run),
      .q_fall (q_fall)
   );

   // High half of the source shows the rising-edge level, low half the falling-edge level.
   assign clk_out = src_clk ? q_rise : q_fall;

endmodule

// File: rtl/cdiv_chk.sv
`timescale 1ns/1ps
module cdiv_chk #(
   parameter int CNT_W = 4,
   parameter int CFG_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pause,
   input logic [CNT_W-1:0] phase,
   input logic             wrap,
   input logic             q_rise,
   input logic             clk_en,
   input logic [CFG_W-1:0] cfg_word
);
   AST_PAUSE_FREEZES_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      pause |=> $stable(phase)); // R9

   AST_PAUSE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      pause |=> !clk_en); // R9

   AST_PAUSE_RISE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      pause |=> !q_rise); // R9

   AST_CFG_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_word) |-> $past(wrap)); // R8

   AST_WRAP_THEN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> clk_en); // R7
endmodule

bind cfg_clk_div cdiv_chk u_cdiv_chk (
   .clk      (src_clk),
   .rst_n    (rst_n),
   .pause    (pause),
   .phase    (phase),
   .wrap     (wrap),
   .q_rise   (q_rise),
   .clk_en   (clk_en),
   .cfg_word ({act_kind, act_n})
);

// File: tb/test_cfg_clk_div.sv
`timescale 1ns/1ps
module test_cfg_clk_div;
   logic       osc_clk = 1'b0;
   logic       ext_clk = 1'b0;
   logic       src_sel = 1'b0;
   logic       rst_n   = 1'b0;
   logic [4:0] div_sel = 5'd0;
   logic       pause   = 1'b0;
   logic       clk_out;
   logic       clk_en;
   logic       sclk;

   int    checks   = 0;
   int    failures = 0;
   string cur_req  = "R1";

   // Reference state: cycles since wrap, window length, period and high time in half-periods.
   int m_k   = 0;
   int m_cyc = 1;
   int m_h   = 2;
   int m_hi  = 1;
   logic e_rise, e_fall, e_stb;

   always #10 osc_clk = ~osc_clk;   // 50 MHz
   always #14 ext_clk = ~ext_clk;
   assign sclk = src_sel ? ext_clk : osc_clk;

   cfg_clk_div i_cfg_clk_div (
      .osc_clk (osc_clk),
      .ext_clk (ext_clk),
      .src_sel (src_sel),
      .rst_n   (rst_n),
      .div_sel (div_sel),
      .pause   (pause),
      .clk_out (clk_out),
      .clk_en  (clk_en)
   );

   task automatic chk(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s at %0t: actual=%b expected=%b", req, what, $time, act, exp);
      end
   endtask

   task automatic load_setting(int code);
      if (code < 16) begin
         m_cyc = code + 1; m_h = 2 * (code + 1); m_hi = code + 1;
      end else if (code == 16) begin
         m_cyc = 3; m_h = 3; m_hi = 2;
      end else if (code == 17) begin
         m_cyc = 5; m_h = 5; m_hi = 3;
      end else begin
         m_cyc = 1; m_h = 2; m_hi = 1;
      end
   endtask

   // Reference model and checker, one source cycle per pass.
   initial begin
      int q;
      int t;
      forever begin
         @(posedge sclk);
         q = src_sel ? 7 : 5;
         if (!rst_n) begin
            m_k = 0; m_cyc = 1; m_h = 2; m_hi = 1;
            #(q);
            chk("R1", "clk_out in reset", clk_out, 1'b0);
            chk("R1", "clk_en in reset", clk_en, 1'b0);
         end else begin
            if (pause) begin
               e_rise = 1'b0; e_fall = 1'b0; e_stb = 1'b0;
            end else begin
               if (m_k == m_cyc - 1) begin
                  load_setting(int'(div_sel));
                  m_k = 0;
               end else begin
                  m_k++;
               end
               t      = 2 * m_k;
               e_rise = ((t % m_h) < m_hi);
               e_fall = (((t + 1) % m_h) < m_hi);
               e_stb  = ((t % m_h) == 0) || (((t + 1) % m_h) == 0);
            end
            #(q);
            chk(cur_req, "clk_out high half", clk_out, e_rise);
            chk("R7", "clk_en", clk_en, e_stb);
            @(negedge sclk);
            #(q);
            chk(cur_req, "clk_out low half", clk_out, e_fall);
         end
      end
   end

   task automatic run_cycles(int n);
      repeat (n) @(negedge sclk);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      failures++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      run_cycles(3);
      rst_n = 1'b1;
      cur_req = "R1";
      run_cycles(6);
      cur_req = "R3";
      for (int c = 1; c < 16; c++) begin
         div_sel = 5'(c);
         run_cycles(2 * (c + 1) + 3);
      end
      cur_req = "R4";
      div_sel = 5'd16;
      run_cycles(14);
      cur_req = "R5";
      div_sel = 5'd17;
      run_cycles(22);
      cur_req = "R8";
      div_sel = 5'd7;
      run_cycles(11);
      div_sel = 5'd2;
      run_cycles(3);
      div_sel = 5'd16;
      run_cycles(10);
      div_sel = 5'd3;
      run_cycles(12);
      cur_req = "R9";
      div_sel = 5'd4;
      run_cycles(3);
      pause = 1'b1;
      run_cycles(4);
      pause = 1'b0;
      run_cycles(12);
      div_sel = 5'd17;
      run_cycles(7);
      pause = 1'b1;
      run_cycles(2);
      pause = 1'b0;
      run_cycles(12);
      cur_req = "R6";
      div_sel = 5'd20;
      run_cycles(8);
      div_sel = 5'd31;
      run_cycles(5);
      cur_req = "R1";
      rst_n = 1'b0;
      run_cycles(2);
      src_sel = 1'b1;
      div_sel = 5'd2;
      run_cycles(3);
      rst_n = 1'b1;
      cur_req = "R2";
      run_cycles(14);
      div_sel = 5'd16;
      run_cycles(9);
      pause = 1'b1;
      run_cycles(3);
      pause = 1'b0;
      div_sel = 5'd5;
      run_cycles(16);
      run_cycles(2);
      finish_run();
   end
endmodule